// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and State Checker

This block watches the command pins of a DDR SDRAM bus from the memory side. On every rising clock edge it captures the clock-enable level, chip select, the three strobes, the two bank-select bits and the address bus. It keeps the clock-enable level of the previous edge so that every decode can see both the old and the new level. From these inputs it produces a command code, the bank index, the row or column address, the auto-precharge flag and the mode-register opcode.

It also tracks whether each of the four banks is open, whether a read or write burst is still running, and which power state the device is in: normal, self refresh, power down or clock suspend. A command that is not allowed in the current state raises an illegal flag for one cycle. Such a command does not change the bank or power state. All outputs are registered, so they describe the edge before the current one.

Top module: `ddr_cmd_decoder`

## Requirements
- R1: All outputs are registered and show the command sampled at the previous rising edge. After reset, cmd_code is 15 (none), illegal is 0, bank_active is 0 and pwr_state is 0 (normal).
- R2: With clock enable high on both edges, the commands decode as follows. cs_n high gives code 0 (deselect). cs_n low with the strobes {ras_n,cas_n,we_n} = 111 gives 1 (no-op), 110 gives 2 (burst stop), 011 gives 3 (activate), 010 gives 4 or 5 (precharge), 101 gives 6 (read), 100 gives 7 (write), 001 gives 10 (auto refresh) and 000 gives 8 or 9 (mode set).
- R3: Activate is legal only when the addressed bank is idle, and it opens that bank. cmd_addr then carries the whole address bus and cmd_bank carries the bank bits.
- R4: Precharge with address bit 8 low closes the bank selected by the bank bits (code 4). With bit 8 high it closes all banks, ignores the bank bits and gives code 5 with cmd_bank 0.
- R5: Read and write are legal only when the addressed bank is open. cmd_addr is address bits 7..0 with zeros above them, and auto_pre copies address bit 8. With auto-precharge the bank still shows open on the sample that reports the command and shows idle on the sample after it.
- R6: Mode set with bank bits 00 gives code 8 and with 01 gives code 9, and mode_op carries the address bus. Both are legal only when all banks are idle. Bank bits 1x give code 15 and illegal.
- R7: Auto refresh and self-refresh entry are legal only when all banks are idle. Self-refresh entry is clock enable going high to low with the refresh strobes; it gives code 11 and pwr_state 1.
- R8: Clock enable going high to low with a deselect or no-op gives code 13. pwr_state becomes 3 (clock suspend) if a burst is running and 2 (power down) otherwise. A read or write keeps a burst running for the next 4 sampled edges in normal state, and a burst stop ends it at once.
- R9: Clock enable going low to high with a deselect or no-op leaves a low-power state. It gives code 12 from self refresh and code 14 from power down or clock suspend, and pwr_state returns to 0. Any other command on that edge is illegal and the state is kept.
- R10: An illegal command raises illegal for exactly one sample, and bank_active and pwr_state keep their values.
- R11: In normal state, clock enable going high to low with any command other than deselect, no-op or the refresh strobes is illegal with code 15. Clock enable low on both edges gives code 15 with no flag.
- R12: cmd_addr is 0 except for codes 3, 6 and 7. mode_op is 0 except for codes 8 and 9. cmd_bank is 0 except for codes 3, 4, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge sampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | ADDR_W | Address bus; bit 8 is the auto-precharge / all-banks bit |
| cmd_code | output | 4 | Decoded command code |
| cmd_bank | output | 2 | Bank index of the command |
| cmd_addr | output | ADDR_W | Row or column address |
| auto_pre | output | 1 | Read or write with auto-precharge |
| mode_op | output | ADDR_W | Mode-register opcode |
| illegal | output | 1 | Command not allowed in the current state |
| bank_active | output | 4 | Open flag per bank |
| pwr_state | output | 2 | 0 normal, 1 self refresh, 2 power down, 3 clock suspend |

## Verification
Directed sequences try each command against an idle bank and against an open bank, which separates legal from illegal decodes. They also try precharge with address bit 8 set and clear, and mode set with every bank value. Power-down entry is tried on the last edge of a burst and on the edge after it, and after a burst stop, which shows whether the burst window is exactly four edges long. Exits are tried with a no-op and with a real command. Long random runs, with clock enable dropping often, mix every strobe pattern with every bank and state, and a bench model checks all outputs on every cycle.

// File: rtl/ddr_cmd_decoder.sv
module ddr_cmd_decoder #(
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 8,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        cmd_code,
  output logic [1:0]        cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              auto_pre,
  output logic [ADDR_W-1:0] mode_op,
  output logic              illegal,
  output logic [3:0]        bank_active,
  output logic [1:0]        pwr_state
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  localparam logic [3:0] C_DESEL = 4'd0,  C_NOP  = 4'd1,  C_BST  = 4'd2,  C_ACT  = 4'd3,
                         C_PRE   = 4'd4,  C_PREA = 4'd5,  C_RD   = 4'd6,  C_WR   = 4'd7,
                         C_MRS   = 4'd8,  C_EMRS = 4'd9,  C_REF  = 4'd10, C_SRE  = 4'd11,
                         C_SRX   = 4'd12, C_PDE  = 4'd13, C_PDX  = 4'd14, C_NONE = 4'd15;
  localparam logic [1:0] P_NORM = 2'd0, P_SREF = 2'd1, P_PDN = 2'd2, P_SUSP = 2'd3;

  logic             cke_prev;
  logic [CNT_W-1:0] burst_cnt;
  logic             ap_pend;
  logic [1:0]       ap_bank;

  logic [3:0]       code_n;
  logic             ill_n;
  logic [3:0]       bank_n;
  logic [1:0]       pwr_n;
  logic [CNT_W-1:0] cnt_n;
  logic             ap_n;
  logic [1:0]       apb_n;

  wire [2:0] rcw       = {ras_n, cas_n, we_n};
  wire       a8        = addr[AP_BIT];
  wire       is_nop    = cs_n | (rcw == 3'b111);
  wire [3:0] pend_mask = ap_pend ? (4'b0001 << ap_bank) : 4'b0000;
  wire [3:0] bank_eff  = bank_active & ~pend_mask;
  wire       bank_on   = bank_eff[ba];
  wire       all_idle  = (bank_eff == 4'b0000);
  wire       busy      = (burst_cnt != '0);
  wire       low_pwr   = (pwr_state != P_NORM);

  always_comb begin
    code_n = C_NONE;
    ill_n  = 1'b0;
    bank_n = bank_eff;
    pwr_n  = pwr_state;
    cnt_n  = (!low_pwr && busy) ? burst_cnt - CNT_W'(1) : burst_cnt;
    ap_n   = 1'b0;
    apb_n  = ap_bank;
    if (low_pwr) begin
      if (!cke_prev && cke) begin
        if (is_nop) begin
          code_n = (pwr_state == P_SREF) ? C_SRX : C_PDX;
          pwr_n  = P_NORM;
        end else begin
          ill_n = 1'b1;
        end
      end
    end else if (cke_prev && !cke) begin
      if (is_nop) begin
        code_n = C_PDE;
        pwr_n  = busy ? P_SUSP : P_PDN;
      end else if (rcw == 3'b001) begin
        code_n = C_SRE;
        if (all_idle) pwr_n = P_SREF;
        else          ill_n = 1'b1;
      end else begin
        ill_n = 1'b1;
      end
    end else if (cke_prev && cke) begin
      if (cs_n) begin
        code_n = C_DESEL;
      end else begin
        case (rcw)
          3'b111: code_n = C_NOP;
          3'b110: begin
            code_n = C_BST;
            cnt_n  = '0;
          end
          3'b011: begin
            code_n = C_ACT;
            if (bank_on) ill_n = 1'b1;
            else         bank_n[ba] = 1'b1;
          end
          3'b010: begin
            if (a8) begin
              code_n = C_PREA;
              bank_n = 4'b0000;
            end else begin
              code_n     = C_PRE;
              bank_n[ba] = 1'b0;
            end
          end
          3'b101, 3'b100: begin
            code_n = we_n ? C_RD : C_WR;
            if (!bank_on) begin
              ill_n = 1'b1;
            end else begin
              cnt_n = CNT_W'(BURST_LEN);
              ap_n  = a8;
              apb_n = ba;
            end
          end
          3'b001: begin
            code_n = C_REF;
            if (!all_idle) ill_n = 1'b1;
          end
          default: begin
            if (ba[1]) begin
              ill_n = 1'b1;
            end else begin
              code_n = ba[0] ? C_EMRS : C_MRS;
              if (!all_idle) ill_n = 1'b1;
            end
          end
        endcase
      end
    end
  end

  wire has_bank = (code_n == C_ACT) | (code_n == C_PRE) | (code_n == C_RD) | (code_n == C_WR);
  wire is_rw    = (code_n == C_RD) | (code_n == C_WR);
  wire is_mode  = (code_n == C_MRS) | (code_n == C_EMRS);
  wire [ADDR_W-1:0] col = {{(ADDR_W-COL_W){1'b0}}, addr[COL_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev    <= 1'b1;
      burst_cnt   <= '0;
      ap_pend     <= 1'b0;
      ap_bank     <= 2'd0;
      bank_active <= 4'b0000;
      pwr_state   <= P_NORM;
      cmd_code    <= C_NONE;
      cmd_bank    <= 2'd0;
      cmd_addr    <= '0;
      auto_pre    <= 1'b0;
      mode_op     <= '0;
      illegal     <= 1'b0;
    end else begin
      cke_prev    <= cke;
      burst_cnt   <= cnt_n;
      ap_pend     <= ap_n;
      ap_bank     <= apb_n;
      bank_active <= ill_n ? bank_eff : bank_n;
      pwr_state   <= ill_n ? pwr_state : pwr_n;
      cmd_code    <= code_n;
      cmd_bank    <= has_bank ? ba : 2'd0;
      cmd_addr    <= (code_n == C_ACT) ? addr : (is_rw ? col : '0);
      auto_pre    <= is_rw & a8;
      mode_op     <= is_mode ? addr : '0;
      illegal     <= ill_n;
    end
  end
endmodule

// File: rtl/ddr_cmd_decoder_chk.sv
module ddr_cmd_decoder_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd_code,
  input logic [1:0]        cmd_bank,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              auto_pre,
  input logic [ADDR_W-1:0] mode_op,
  input logic              illegal,
  input logic [3:0]        bank_active,
  input logic [1:0]        pwr_state
);
  assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd3 && !illegal) |-> bank_active[cmd_bank]);

  assert_prea_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 4'd5) |-> (bank_active == 4'b0000 && cmd_bank == 2'd0));

  assert_rw_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == 4'd6 || cmd_code == 4'd7) && !illegal) |-> bank_active[cmd_bank]);

  assert_ap_only_rw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre |-> (cmd_code == 4'd6 || cmd_code == 4'd7));

  assert_lowpwr_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'd0) |-> (cmd_code inside {4'd11, 4'd13, 4'd15}));

  assert_pwr_change_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != $past(pwr_state)) |-> (cmd_code inside {4'd11, 4'd12, 4'd13, 4'd14}));

  assert_illegal_keeps_pwr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable(pwr_state));

  assert_mode_op_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code != 4'd8 && cmd_code != 4'd9) |-> (mode_op == '0));

  assert_addr_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_code inside {4'd3, 4'd6, 4'd7}) |-> (cmd_addr == '0));
endmodule

bind ddr_cmd_decoder ddr_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ddr_cmd_decoder_tb.sv
`timescale 1ns/1ps
module ddr_cmd_decoder_tb;
  localparam int AW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [3:0] cmd_code;
  logic [1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;
  logic auto_pre, illegal;
  logic [AW-1:0] mode_op;
  logic [3:0] bank_active;
  logic [1:0] pwr_state;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  ddr_cmd_decoder #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .auto_pre(auto_pre), .mode_op(mode_op), .illegal(illegal),
    .bank_active(bank_active), .pwr_state(pwr_state));

  always #2.5 clk = ~clk;

  // bench model state
  bit m_ckep = 1'b1;
  logic [3:0] m_bank = 4'b0;
  logic [1:0] m_pwr = 2'd0;
  int m_left = 0;
  bit m_ap = 1'b0;
  logic [1:0] m_apb = 2'd0;
  logic [3:0] e_code = 4'd15;
  logic [1:0] e_bank = 2'd0;
  logic [AW-1:0] e_addr = '0, e_op = '0;
  bit e_ap = 1'b0, e_ill = 1'b0;

  task automatic model_step();
    logic [3:0] open_now, nb;
    logic [1:0] np;
    bit ill, nop;
    logic [2:0] s;
    int left;
    bit nap;
    logic [3:0] c;
    s = {ras_n, cas_n, we_n};
    nop = cs_n || s == 3'b111;
    open_now = m_bank;
    if (m_ap) open_now[m_apb] = 1'b0;
    nb = open_now; np = m_pwr; ill = 0; c = 4'd15; nap = 0;
    left = (m_pwr == 0 && m_left > 0) ? m_left - 1 : m_left;
    if (m_pwr != 0) begin
      if (!m_ckep && cke) begin
        if (nop) begin c = (m_pwr == 1) ? 4'd12 : 4'd14; np = 0; end
        else ill = 1;
      end
    end else if (m_ckep && !cke) begin
      if (nop) begin c = 4'd13; np = (m_left > 0) ? 2'd3 : 2'd2; end
      else if (!cs_n && s == 3'b001) begin
        c = 4'd11;
        if (open_now == 0) np = 1; else ill = 1;
      end else ill = 1;
    end else if (m_ckep && cke) begin
      if (cs_n) c = 4'd0;
      else if (s == 3'b111) c = 4'd1;
      else if (s == 3'b110) begin c = 4'd2; left = 0; end
      else if (s == 3'b011) begin c = 4'd3; if (open_now[ba]) ill = 1; else nb[ba] = 1; end
      else if (s == 3'b010) begin
        if (addr[8]) begin c = 4'd5; nb = 0; end else begin c = 4'd4; nb[ba] = 0; end
      end else if (s[2:1] == 2'b10) begin
        c = we_n ? 4'd6 : 4'd7;
        if (!open_now[ba]) ill = 1;
        else begin left = 4; nap = addr[8]; m_apb = ba; end
      end else if (s == 3'b001) begin c = 4'd10; if (open_now != 0) ill = 1; end
      else begin
        if (ba[1]) ill = 1;
        else begin c = ba[0] ? 4'd9 : 4'd8; if (open_now != 0) ill = 1; end
      end
    end
    e_code = c; e_ill = ill;
    e_bank = (c inside {4'd3, 4'd4, 4'd6, 4'd7}) ? ba : 2'd0;
    e_addr = (c == 4'd3) ? addr : ((c == 4'd6 || c == 4'd7) ? {4'h0, addr[7:0]} : '0);
    e_ap = (c == 4'd6 || c == 4'd7) && addr[8];
    e_op = (c == 4'd8 || c == 4'd9) ? addr : '0;
    m_bank = ill ? open_now : nb;
    if (!ill) m_pwr = np;
    m_left = left; m_ap = nap; m_ckep = cke;
  endtask

  task automatic compare(string req);
    checks++;
    if (cmd_code !== e_code || cmd_bank !== e_bank || cmd_addr !== e_addr ||
        auto_pre !== e_ap || mode_op !== e_op || illegal !== e_ill ||
        bank_active !== m_bank || pwr_state !== m_pwr) begin
      failures++;
      $display("FAIL %s: got code=%0d bank=%0d addr=%h ap=%0b op=%h ill=%0b banks=%b pwr=%0d exp code=%0d bank=%0d addr=%h ap=%0b op=%h ill=%0b banks=%b pwr=%0d",
               req, cmd_code, cmd_bank, cmd_addr, auto_pre, mode_op, illegal, bank_active, pwr_state,
               e_code, e_bank, e_addr, e_ap, e_op, e_ill, m_bank, m_pwr);
    end
  endtask

  task automatic cyc(string req, bit k, bit cs, logic [2:0] s, logic [1:0] b, logic [AW-1:0] a);
    @(negedge clk);
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = s; ba = b; addr = a;
    @(posedge clk);
    model_step();
    #1 compare(req);
  endtask

  task automatic nop(string req, bit k);
    cyc(req, k, 1'b0, 3'b111, 2'd0, '0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_n = 1'b1;

    cyc("R3", 1, 0, 3'b011, 2'd1, 12'hABC);
    cyc("R10", 1, 0, 3'b011, 2'd1, 12'h123);
    cyc("R5", 1, 0, 3'b101, 2'd2, 12'h055);
    cyc("R5", 1, 0, 3'b101, 2'd1, 12'h155);
    nop("R5", 1);
    nop("R5", 1);
    cyc("R3", 1, 0, 3'b011, 2'd0, 12'h001);
    cyc("R3", 1, 0, 3'b011, 2'd3, 12'hFFF);
    cyc("R4", 1, 0, 3'b010, 2'd0, 12'h000);
    cyc("R4", 1, 0, 3'b010, 2'd2, 12'h100);
    cyc("R6", 1, 0, 3'b000, 2'd0, 12'h032);
    cyc("R6", 1, 0, 3'b000, 2'd1, 12'h002);
    cyc("R6", 1, 0, 3'b000, 2'd2, 12'h777);
    cyc("R7", 1, 0, 3'b001, 2'd0, 12'h000);
    cyc("R3", 1, 0, 3'b011, 2'd0, 12'h010);
    cyc("R7", 1, 0, 3'b001, 2'd0, 12'h000);
    cyc("R7", 0, 0, 3'b001, 2'd0, 12'h000);
    cyc("R11", 1, 1, 3'b111, 2'd0, 12'h000);
    cyc("R4", 1, 0, 3'b010, 2'd0, 12'h000);
    // burst window edges
    cyc("R3", 1, 0, 3'b011, 2'd2, 12'h222);
    cyc("R5", 1, 0, 3'b100, 2'd2, 12'h033);
    nop("R8", 1); nop("R8", 1); nop("R8", 1);
    nop("R8", 0);
    nop("R8", 0);
    nop("R9", 1);
    cyc("R5", 1, 0, 3'b100, 2'd2, 12'h044);
    nop("R8", 1); nop("R8", 1); nop("R8", 1); nop("R8", 1);
    nop("R8", 0);
    cyc("R9", 1, 0, 3'b011, 2'd1, 12'h000);
    nop("R9", 0);
    cyc("R9", 1, 1, 3'b000, 2'd0, 12'h000);
    cyc("R5", 1, 0, 3'b101, 2'd2, 12'h011);
    cyc("R8", 1, 0, 3'b110, 2'd0, 12'h000);
    nop("R8", 0);
    nop("R9", 1);
    cyc("R4", 1, 0, 3'b010, 2'd3, 12'h100);
    cyc("R7", 0, 0, 3'b001, 2'd0, 12'h000);
    nop("R7", 0);
    cyc("R9", 1, 1, 3'b010, 2'd0, 12'h000);
    cyc("R11", 0, 0, 3'b011, 2'd0, 12'h000);
    nop("R11", 0);
    nop("R11", 1);
    nop("R12", 1);

    for (int i = 0; i < 4000; i++) begin
      bit k, cs;
      logic [2:0] s;
      k = ($urandom % 6) != 0;
      cs = ($urandom % 8) == 0;
      s = 3'($urandom);
      cyc("R2", k, cs, s, 2'($urandom), AW'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule